// File: doc/BRIEF.md
# Backlight PWM Level Generator

This block turns a host-selected backlight power level into a pulse-width-modulated output. The host writes a level between zero and a configurable maximum. The block scales that level into a compare value against a free-running counter with a fixed period. The output is high for the part of each period in which the counter is below that compare value.

A level write first goes into a shadow compare register. The running period keeps its old duty, and the new duty starts at the next counter wrap. This means no period is ever cut short or stretched.

Three inputs shape the output. A level of zero turns the output fully off. A full-scale level is clamped just below the period, so the output always drops for at least one clock. A write that leaves the level unchanged has no effect. The enable input stops the counter and forces the output low. When the enable returns, a fresh period starts.

Top module: `backlight_pwm`

## Requirements
- R1: While enabled, the counter steps through 0 to PERIOD-1 (default PERIOD = 9000) at one step per clock. pwm_o is high exactly while the counter is below the active compare value. The output therefore repeats every PERIOD clocks and is high for compare-value clocks in each period.
- R2: An accepted level L with 0 < L sets the compare value to floor((PERIOD-1) * L / MAX_LVL), computed in 32-bit arithmetic.
- R3: When the scaled value from R2 is PERIOD-1 or more, the compare value becomes PERIOD-2.
- R4: An accepted level of 0 sets the compare value to 0, so pwm_o stays low for the whole period.
- R5: A write whose level, after saturation, equals the stored level is ignored. The stored level and the compare value both stay as they were.
- R6: After reset, the stored level is (MAX_LVL+1)/2 and the compare value is PERIOD/2. These are 50 and 4500 with the defaults; with this bench's PERIOD = 200, the compare value is 100. pwm_o is low while en_i is low.
- R7: A new compare value takes effect at the first counter wrap after the write. The period that is running when the write arrives keeps its old high time.
- R8: A written level above MAX_LVL (default 100) is stored as MAX_LVL.
- R9: lvl_o shows the last accepted level, starting in the cycle after the accepting strobe. lvl_o never changes without a strobe.
- R10: If en_i is low at a clock edge, pwm_o is low after that edge and the counter returns to 0. The edge at which en_i is first seen high again starts a new period from count 0, using the latest compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs the counter and output when high |
| lvl_we_i | input | 1 | Level write strobe, one cycle per write |
| lvl_i | input | LVL_W | Requested power level |
| pwm_o | output | 1 | Backlight PWM output, active high |
| lvl_o | output | LVL_W | Currently stored power level |

## Verification
The assertions assume that lvl_i carries only a value of LVL_W bits, whatever its size, since saturation must handle anything above MAX_LVL. They also assume that en_i and lvl_we_i are free to change on any cycle. The stimulus drives all inputs on the falling clock edge. Random levels are drawn from a range that extends past MAX_LVL, so saturation and ignored repeats both occur. After each level write, the bench waits a full period for the compare value to load before it measures the high time over a complete period.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  // Scale a power level onto the counter range. Zero stays zero, and the
  // result is clamped to one below the reload value.
  function automatic logic [31:0] scale_cmp(input logic [31:0] lvl,
                                            input logic [31:0] reload,
                                            input logic [31:0] max_lvl);
    logic [31:0] prod;
    if (lvl == 32'd0) return 32'd0;
    prod = (reload * lvl) / max_lvl;
    if (prod >= reload) prod = reload - 32'd1;
    return prod;
  endfunction

endpackage

// File: rtl/bl_level_ctl.sv
module bl_level_ctl #(
  parameter int MAX_LVL = 100,
  parameter int RELOAD  = 8999,
  parameter int LVL_W   = 7,
  parameter int CNT_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_we_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [CNT_W-1:0] shd_o
);
  localparam logic [LVL_W-1:0] MaxLvl = LVL_W'(MAX_LVL);
  localparam logic [LVL_W-1:0] RstLvl = LVL_W'((MAX_LVL + 1) / 2);
  localparam logic [CNT_W-1:0] RstCmp = CNT_W'((RELOAD + 1) / 2);

  logic [LVL_W-1:0] lvl_q, lvl_sat;
  logic [CNT_W-1:0] shd_q;
  logic [31:0]      cmp_new;
  logic             accept;

  always_comb begin
    lvl_sat = (lvl_i > MaxLvl) ? MaxLvl : lvl_i;
    accept  = lvl_we_i && (lvl_sat != lvl_q);
    cmp_new = bl_pwm_pkg::scale_cmp(32'(lvl_sat), 32'(RELOAD), 32'(MAX_LVL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= RstLvl;
      shd_q <= RstCmp;
    end else if (accept) begin
      lvl_q <= lvl_sat;
      shd_q <= cmp_new[CNT_W-1:0];
    end
  end

  assign lvl_o = lvl_q;
  assign shd_o = shd_q;
endmodule

// File: rtl/bl_pwm_timer.sv
module bl_pwm_timer #(
  parameter int RELOAD = 8999,
  parameter int CNT_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] shd_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] Reload = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] RstCmp = CNT_W'((RELOAD + 1) / 2);

  logic [CNT_W-1:0] cnt_q, act_q;
  logic             run_q, wrap;

  assign wrap = (cnt_q == Reload);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RstCmp;
      run_q <= 1'b0;
    end else begin
      run_q <= en_i;
      if (!en_i)      cnt_q <= '0;
      else if (run_q) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      // shadow moves to active only at a period boundary or while idle
      if (!run_q || wrap) act_q <= shd_i;
    end
  end

  assign pwm_o = run_q && (cnt_q < act_q);
endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm #(
  parameter int PERIOD  = 9000,
  parameter int MAX_LVL = 100,
  localparam int RELOAD = PERIOD - 1,
  localparam int LVL_W  = $clog2(MAX_LVL + 1),
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lvl_we_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             pwm_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [CNT_W-1:0] shd;

  bl_level_ctl #(
    .MAX_LVL(MAX_LVL), .RELOAD(RELOAD), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) u_lvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_we_i(lvl_we_i),
    .lvl_i   (lvl_i),
    .lvl_o   (lvl_o),
    .shd_o   (shd)
  );

  bl_pwm_timer #(
    .RELOAD(RELOAD), .CNT_W(CNT_W)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .shd_i (shd),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int PERIOD  = 9000,
  parameter int MAX_LVL = 100,
  parameter int LVL_W   = 7,
  parameter int CNT_W   = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             lvl_we_i,
  input logic [LVL_W-1:0] lvl_i,
  input logic             pwm_o,
  input logic [LVL_W-1:0] lvl_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_i
);
  a_r8_level_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o <= LVL_W'(MAX_LVL));

  a_r9_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_we_i |=> $stable(lvl_o));

  a_r5_same_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_we_i && lvl_i == lvl_o) |=> $stable(lvl_o));

  a_r7_no_midperiod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> $stable(act_i));

  a_r3_below_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i < CNT_W'(PERIOD - 1));

  a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> !pwm_o);

  a_r10_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  a_r1_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(PERIOD));
endmodule

bind backlight_pwm bl_pwm_chk #(
  .PERIOD(PERIOD), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .lvl_we_i(lvl_we_i),
  .lvl_i   (lvl_i),
  .pwm_o   (pwm_o),
  .lvl_o   (lvl_o),
  .cnt_i   (u_tmr.cnt_q),
  .act_i   (u_tmr.act_q)
);

// File: tb/backlight_pwm_tb.sv
module backlight_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD  = 200;
  localparam int MAX_LVL = 100;
  localparam int RELOAD  = PERIOD - 1;
  localparam int LVL_W   = $clog2(MAX_LVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic we = 1'b0;
  logic [LVL_W-1:0] lvl = '0;
  logic pwm;
  logic [LVL_W-1:0] lvl_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backlight_pwm #(.PERIOD(PERIOD), .MAX_LVL(MAX_LVL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .lvl_we_i(we), .lvl_i(lvl),
    .pwm_o(pwm), .lvl_o(lvl_rd)
  );

  function automatic int exp_cmp(int l);
    int p;
    if (l == 0) return 0;
    p = (RELOAD * l) / MAX_LVL;
    if (p >= RELOAD) p = RELOAD - 1;
    return p;
  endfunction

  function automatic int sat(int l);
    return (l > MAX_LVL) ? MAX_LVL : l;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int v);
    @(negedge clk);
    we = 1'b1;
    lvl = LVL_W'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic duty(output int hi);
    repeat (PERIOD + 2) @(negedge clk);
    hi = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hi += int'(pwm);
    end
  endtask

  initial begin
    int hi, st, ec, v, gap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset level", int'(lvl_rd), (MAX_LVL + 1) / 2);
    chk("R10 off while disabled", int'(pwm), 0);
    st = (MAX_LVL + 1) / 2;
    ec = PERIOD / 2;

    en = 1'b1;
    duty(hi); chk("R6 reset duty", hi, ec);

    wr(st);
    chk("R5 same level kept", int'(lvl_rd), st);
    duty(hi); chk("R5 compare not recomputed", hi, ec);

    wr(30); st = 30; ec = exp_cmp(30);
    chk("R9 readback", int'(lvl_rd), 30);
    duty(hi); chk("R2 scaled duty 30", hi, 59);

    wr(120); st = MAX_LVL; ec = exp_cmp(MAX_LVL);
    chk("R8 saturated level", int'(lvl_rd), MAX_LVL);
    duty(hi); chk("R3 clamped duty", hi, RELOAD - 1);

    wr(0); st = 0; ec = 0;
    chk("R9 readback zero", int'(lvl_rd), 0);
    duty(hi); chk("R4 zero duty", hi, 0);

    for (int k = 0; k < 14; k++) begin
      v = int'($urandom % (MAX_LVL + 20));
      if (sat(v) != st) begin
        st = sat(v);
        ec = exp_cmp(st);
      end
      wr(v);
      chk("R9 random readback", int'(lvl_rd), st);
      duty(hi); chk("R2 random duty", hi, ec);
    end

    // R1: distance between rising edges equals the period
    wr(25);
    repeat (PERIOD + 2) @(negedge clk);
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    gap = 0;
    while (pwm) begin @(negedge clk); gap++; end
    chk("R1 high time", gap, exp_cmp(25));
    while (!pwm) begin @(negedge clk); gap++; end
    chk("R1 period", gap, PERIOD);

    // R10: disable forces low
    en = 1'b0;
    @(negedge clk);
    chk("R10 low after disable", int'(pwm), 0);
    hi = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hi += int'(pwm);
    end
    chk("R10 stays low", hi, 0);

    // R7: write mid-period, old duty holds until the wrap
    wr(60);
    en = 1'b1;
    @(negedge clk);                 // count 0
    chk("R10 restart high", int'(pwm), 1);
    repeat (50) @(negedge clk);     // count 50
    wr(0);                          // count 52
    repeat (8) @(negedge clk);      // count 60
    chk("R7 old duty holds", int'(pwm), 1);
    repeat (PERIOD) @(negedge clk); // count 60 of next period
    chk("R7 new duty at wrap", int'(pwm), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule